// File: doc/BRIEF.md
# BCD calendar clock counter

This block keeps time of day and calendar date in packed BCD: seconds, minutes, hours in 24-hour form, day of week, date of month, month and a two-digit year. A clock-enable input at the crystal rate drives a binary prescaler. Each carry out of the prescaler is one second, and that second ripples through the field chain. The date limit follows the month, and February follows a year-divisible-by-four leap rule, which is correct for years 2000 to 2099.

A one-cycle load pulse writes every field at once and restarts the second. A stop input freezes the prescaler and all fields. A tap of the prescaler gives the square wave used for the frequency test. All outputs come straight from registers. The prescaler width and the test tap are parameters, so a bench can shorten the second.

Top module: `bcd_calendar_counter`

## Requirements
- R1: After reset, seconds, minutes, hours and year read 8'h00, and day of week, date and month read 8'h01.
- R2: Seconds and minutes count 8'h00 to 8'h59 in BCD. Each wraps to 8'h00 and advances the next field only when it steps from 8'h59.
- R3: Hours count 8'h00 to 8'h23. Stepping from 8'h23 wraps to 8'h00 and advances both the day of week and the date.
- R4: Day of week counts 8'h01 to 8'h07 and wraps from 8'h07 to 8'h01.
- R5: The date wraps to 8'h01 after the month's last day and advances the month. The last day is 31 for months 01, 03, 05, 07, 08, 10 and 12, and 30 for months 04, 06, 09 and 11.
- R6: The last day of February is 29 when the BCD year is divisible by 4, including 00, and 28 otherwise.
- R7: The month wraps from 8'h12 to 8'h01 and advances the year. The year wraps from 8'h99 to 8'h00.
- R8: While stop_i is 1, neither the prescaler nor any field changes.
- R9: A load_i pulse replaces all seven fields with the load inputs and clears the prescaler. The seconds field then advances on the 2^PRE_BITS-th enabled cycle after the load (32768 at default).
- R10: ftest_o is bit FT_TAP of the prescaler. It is a square wave with a period of 2^(FT_TAP+1) enabled cycles, which is 512 Hz at the defaults.
- R11: A field that holds an illegal BCD code, or a value above its maximum, goes to its minimum on its next step and does not advance the next field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| osc_en_i | input | 1 | One-cycle enable at the crystal rate |
| stop_i | input | 1 | Oscillator stop; 1 freezes the counter |
| load_i | input | 1 | Load all fields and clear the prescaler |
| ld_sec_i | input | 8 | Seconds value to load |
| ld_min_i | input | 8 | Minutes value to load |
| ld_hour_i | input | 8 | Hours value to load |
| ld_dow_i | input | 8 | Day-of-week value to load |
| ld_date_i | input | 8 | Date value to load |
| ld_mon_i | input | 8 | Month value to load |
| ld_year_i | input | 8 | Year value to load |
| sec_o | output | 8 | Seconds in BCD |
| min_o | output | 8 | Minutes in BCD |
| hour_o | output | 8 | Hours in BCD |
| dow_o | output | 8 | Day of week in BCD |
| date_o | output | 8 | Date in BCD |
| mon_o | output | 8 | Month in BCD |
| year_o | output | 8 | Year in BCD |
| ftest_o | output | 1 | Frequency test square wave |

## Verification
The bench loads times just before the ends of minutes, days, 30- and 31-day months, February in leap and common years, and the year 99. A design with a wrong month table, or with the leap test done on raw BCD bits, would show 03/01 where 02/29 is due, or the reverse. Codes such as 8'h7A or 8'h13 are loaded to show that a bad field falls to its minimum without carrying; a carry there would shift minutes or years one step too early. Stop windows in the middle of a second, and exact cycle counts after a load, expose a prescaler that keeps running while stopped, or that the load does not clear.

// File: rtl/cal_pkg.sv
package cal_pkg;

  function automatic logic bcd_ok(input logic [7:0] v);
    return (v[7:4] <= 4'd9) && (v[3:0] <= 4'd9);
  endfunction

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // divisible by 4: even tens need ones 0/4/8, odd tens need ones 2/6
  function automatic logic bcd_leap(input logic [7:0] y);
    if (y[4]) return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
  endfunction

endpackage

// File: rtl/cal_prescaler.sv
module cal_prescaler #(
  parameter int PRE_BITS = 15,
  parameter int FT_TAP   = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  output logic wrap_o,
  output logic ftest_o
);
  logic [PRE_BITS-1:0] cnt_q;

  assign wrap_o  = en_i && !clr_i && (&cnt_q);
  assign ftest_o = cnt_q[FT_TAP];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (en_i)  cnt_q <= cnt_q + 1'b1;
  end

  p_idle_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i && !clr_i |=> $stable(ftest_o));

endmodule

// File: rtl/cal_month_len.sv
module cal_month_len (
  input  logic [7:0] mon_i,
  input  logic [7:0] year_i,
  output logic [7:0] last_o
);
  import cal_pkg::*;

  always_comb begin
    unique case (mon_i)
      8'h02:                      last_o = bcd_leap(year_i) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_o = 8'h30;
      default:                    last_o = 8'h31;
    endcase
  end

endmodule

// File: rtl/cal_bcd_field.sv
module cal_bcd_field #(
  parameter logic [7:0] MIN_VAL = 8'h00
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic [7:0] load_val_i,
  input  logic       step_i,
  input  logic [7:0] max_i,
  output logic [7:0] val_o,
  output logic       carry_o
);
  import cal_pkg::*;

  logic [7:0] q, nxt;
  logic       bad;

  assign bad     = !bcd_ok(q) || (q > max_i);
  assign carry_o = step_i && !load_i && !bad && (q == max_i);
  assign val_o   = q;

  always_comb begin
    if (bad || q == max_i) nxt = MIN_VAL;
    else                   nxt = bcd_inc(q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q <= MIN_VAL;
    else if (load_i) q <= load_val_i;
    else if (step_i) q <= nxt;
  end

  p_step_legal_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !load_i |=> bcd_ok(val_o) && (val_o >= MIN_VAL));
  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i && !load_i |=> $stable(val_o));

endmodule

// File: rtl/bcd_calendar_counter.sv
module bcd_calendar_counter #(
  parameter int PRE_BITS = 15,
  parameter int FT_TAP   = 5
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       osc_en_i,
  input  logic       stop_i,
  input  logic       load_i,
  input  logic [7:0] ld_sec_i,
  input  logic [7:0] ld_min_i,
  input  logic [7:0] ld_hour_i,
  input  logic [7:0] ld_dow_i,
  input  logic [7:0] ld_date_i,
  input  logic [7:0] ld_mon_i,
  input  logic [7:0] ld_year_i,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o,
  output logic [7:0] dow_o,
  output logic [7:0] date_o,
  output logic [7:0] mon_o,
  output logic [7:0] year_o,
  output logic       ftest_o
);
  logic run, tick;
  logic c_sec, c_min, c_hour, c_dow, c_date, c_mon, c_year;
  logic [7:0] date_last;

  assign run = osc_en_i && !stop_i;

  cal_prescaler #(.PRE_BITS(PRE_BITS), .FT_TAP(FT_TAP)) u_pre (
    .clk_i, .rst_ni, .clr_i(load_i), .en_i(run), .wrap_o(tick), .ftest_o
  );

  cal_month_len u_len (.mon_i(mon_o), .year_i(year_o), .last_o(date_last));

  cal_bcd_field #(.MIN_VAL(8'h00)) u_sec (
    .clk_i, .rst_ni, .load_i, .load_val_i(ld_sec_i), .step_i(tick),
    .max_i(8'h59), .val_o(sec_o), .carry_o(c_sec));
  cal_bcd_field #(.MIN_VAL(8'h00)) u_min (
    .clk_i, .rst_ni, .load_i, .load_val_i(ld_min_i), .step_i(c_sec),
    .max_i(8'h59), .val_o(min_o), .carry_o(c_min));
  cal_bcd_field #(.MIN_VAL(8'h00)) u_hour (
    .clk_i, .rst_ni, .load_i, .load_val_i(ld_hour_i), .step_i(c_min),
    .max_i(8'h23), .val_o(hour_o), .carry_o(c_hour));
  cal_bcd_field #(.MIN_VAL(8'h01)) u_dow (
    .clk_i, .rst_ni, .load_i, .load_val_i(ld_dow_i), .step_i(c_hour),
    .max_i(8'h07), .val_o(dow_o), .carry_o(c_dow));
  cal_bcd_field #(.MIN_VAL(8'h01)) u_date (
    .clk_i, .rst_ni, .load_i, .load_val_i(ld_date_i), .step_i(c_hour),
    .max_i(date_last), .val_o(date_o), .carry_o(c_date));
  cal_bcd_field #(.MIN_VAL(8'h01)) u_mon (
    .clk_i, .rst_ni, .load_i, .load_val_i(ld_mon_i), .step_i(c_date),
    .max_i(8'h12), .val_o(mon_o), .carry_o(c_mon));
  cal_bcd_field #(.MIN_VAL(8'h00)) u_year (
    .clk_i, .rst_ni, .load_i, .load_val_i(ld_year_i), .step_i(c_mon),
    .max_i(8'h99), .val_o(year_o), .carry_o(c_year));

  p_load_all_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (sec_o == $past(ld_sec_i)) && (date_o == $past(ld_date_i))
               && (year_o == $past(ld_year_i)));
  p_stop_freeze_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i && !load_i |=> $stable(sec_o) && $stable(ftest_o));
  p_year_wrap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    c_year |=> year_o == 8'h00);
  p_dow_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    c_hour |=> (dow_o >= 8'h01) && (dow_o <= 8'h07));
  p_date_wrap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    c_date |=> date_o == 8'h01);

endmodule

// File: tb/bcd_calendar_counter_tb_top.sv
module bcd_calendar_counter_tb_top;
  localparam int PB  = 6;
  localparam int FT  = 5;
  localparam int SEC = 1 << PB;

  logic clk = 1'b0, rst_n = 1'b0;
  logic osc_en = 1'b1, stop = 1'b0, load = 1'b0;
  logic [7:0] l_sec = 0, l_min = 0, l_hr = 0, l_dow = 1, l_date = 1, l_mon = 1, l_yr = 0;
  logic [7:0] sec, mn, hr, dow, date, mon, yr;
  logic ftest;
  int   osc_mode = 0;
  int   total = 0, bad = 0;
  bit   done = 0;
  string phase = "R1 reset";

  int m_pre, m_sec, m_min, m_hr, m_dow, m_date, m_mon, m_yr;

  always #5ns clk = ~clk;

  bcd_calendar_counter #(.PRE_BITS(PB), .FT_TAP(FT)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .osc_en_i(osc_en), .stop_i(stop), .load_i(load),
    .ld_sec_i(l_sec), .ld_min_i(l_min), .ld_hour_i(l_hr), .ld_dow_i(l_dow),
    .ld_date_i(l_date), .ld_mon_i(l_mon), .ld_year_i(l_yr),
    .sec_o(sec), .min_o(mn), .hour_o(hr), .dow_o(dow), .date_o(date),
    .mon_o(mon), .year_o(yr), .ftest_o(ftest));

  function automatic int dec(int v); return (v >> 4) * 10 + (v & 15); endfunction
  function automatic int tobcd(int d); return ((d / 10) << 4) | (d % 10); endfunction
  function automatic bit legal(int v); return ((v >> 4) < 10) && ((v & 15) < 10); endfunction

  function automatic int mlen(int m, int y);
    case (m)
      8'h02: return (dec(y) % 4 == 0) ? 29 : 28;
      8'h04, 8'h06, 8'h09, 8'h11: return 30;
      default: return 31;
    endcase
  endfunction

  function automatic bit adv(inout int v, input int lo, input int hi);
    if (!legal(v) || dec(v) > hi) begin v = tobcd(lo); return 0; end
    if (dec(v) == hi) begin v = tobcd(lo); return 1; end
    v = tobcd(dec(v) + 1);
    return 0;
  endfunction

  // behavioural reference, updated on the same edges as the design
  always @(posedge clk or negedge rst_n) begin
    bit c, d;
    int lim;
    if (!rst_n) begin
      m_pre = 0; m_sec = 0; m_min = 0; m_hr = 0;
      m_dow = 1; m_date = 1; m_mon = 1; m_yr = 0;
    end else if (load) begin
      m_pre = 0; m_sec = l_sec; m_min = l_min; m_hr = l_hr;
      m_dow = l_dow; m_date = l_date; m_mon = l_mon; m_yr = l_yr;
    end else if (osc_en && !stop) begin
      m_pre = m_pre + 1;
      if (m_pre == SEC) begin
        m_pre = 0;
        c = adv(m_sec, 0, 59);
        if (c) c = adv(m_min, 0, 59);
        if (c) c = adv(m_hr, 0, 23);
        if (c) begin
          lim = mlen(m_mon, m_yr);
          d = adv(m_dow, 1, 7);
          c = adv(m_date, 1, lim);
        end
        if (c) c = adv(m_mon, 1, 12);
        if (c) c = adv(m_yr, 0, 99);
      end
    end
  end

  task automatic chk(string tag, string what, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h at %0t", tag, what, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(phase, "sec", sec, m_sec);
      chk(phase, "min", mn, m_min);
      chk(phase, "hour", hr, m_hr);
      chk(phase, "dow", dow, m_dow);
      chk(phase, "date", date, m_date);
      chk(phase, "mon", mon, m_mon);
      chk(phase, "year", yr, m_yr);
      chk(phase, "ftest", ftest, (m_pre >> FT) & 1);
    end
  end

  always @(negedge clk) osc_en = (osc_mode == 0) ? 1'b1 : ~osc_en;

  task automatic cyc(int n); repeat (n) @(negedge clk); endtask

  task automatic do_load(int s, int m, int h, int w, int d, int mo, int y);
    @(negedge clk);
    load = 1; l_sec = 8'(s); l_min = 8'(m); l_hr = 8'(h); l_dow = 8'(w);
    l_date = 8'(d); l_mon = 8'(mo); l_yr = 8'(y);
    @(negedge clk);
    load = 0;
  endtask

  task automatic finish_up();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #2_000_000ns;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_up();
  end

  initial begin
    cyc(3);
    rst_n = 1;
    cyc(1);
    chk("R1", "sec", sec, 8'h00); chk("R1", "dow", dow, 8'h01);
    chk("R1", "date", date, 8'h01); chk("R1", "mon", mon, 8'h01);
    chk("R1", "year", yr, 8'h00);

    phase = "R9 load timing";
    do_load(8'h30, 8'h10, 8'h05, 8'h03, 8'h15, 8'h06, 8'h42);
    chk("R9", "sec after load", sec, 8'h30);
    phase = "R10 ftest";
    cyc(31); chk("R10", "ftest low half", ftest, 0);
    cyc(1);  chk("R10", "ftest high half", ftest, 1);
    cyc(31); chk("R9", "sec before full second", sec, 8'h30);
    cyc(1);  chk("R9", "sec after full second", sec, 8'h31);
    chk("R10", "ftest back low", ftest, 0);

    phase = "R2 R3 R4 R7 year end";
    do_load(8'h55, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99);
    cyc(5 * SEC);
    chk("R2", "min wrap", mn, 8'h00); chk("R3", "hour wrap", hr, 8'h00);
    chk("R4", "dow wrap", dow, 8'h01); chk("R7", "mon wrap", mon, 8'h01);
    chk("R7", "year wrap", yr, 8'h00);

    phase = "R6 leap";
    do_load(8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h24);
    cyc(SEC); chk("R6", "feb 29 leap", date, 8'h29);
    do_load(8'h59, 8'h59, 8'h23, 8'h02, 8'h29, 8'h02, 8'h24);
    cyc(SEC); chk("R6", "mar after 29", mon, 8'h03);
    do_load(8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h23);
    cyc(SEC); chk("R6", "common feb end", date, 8'h01);
    chk("R6", "common feb month", mon, 8'h03);
    do_load(8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h00);
    cyc(SEC); chk("R6", "year 00 leap", date, 8'h29);

    phase = "R5 month length";
    do_load(8'h59, 8'h59, 8'h23, 8'h01, 8'h30, 8'h04, 8'h10);
    cyc(SEC); chk("R5", "apr 30 wrap", mon, 8'h05);
    do_load(8'h59, 8'h59, 8'h23, 8'h01, 8'h30, 8'h01, 8'h10);
    cyc(SEC); chk("R5", "jan 31 reached", date, 8'h31);

    phase = "R8 stop";
    do_load(8'h20, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
    cyc(20); stop = 1; cyc(3 * SEC);
    chk("R8", "sec frozen", sec, 8'h20);
    stop = 0; cyc(SEC - 20);
    chk("R8", "resumes where it stopped", sec, 8'h21);

    phase = "R11 illegal";
    do_load(8'h7A, 8'h5F, 8'h25, 8'h09, 8'h45, 8'h13, 8'hA0);
    cyc(SEC);
    chk("R11", "sec to min", sec, 8'h00); chk("R11", "min no carry", mn, 8'h5F);
    cyc(60 * SEC);
    chk("R11", "min to min", mn, 8'h00); chk("R11", "hour no carry", hr, 8'h25);

    phase = "R2 R5 R6 R7 random ends";
    osc_mode = 1;
    for (int i = 0; i < 40; i++) begin
      int mo, y, d;
      mo = 1 + int'($urandom % 12);
      y  = int'($urandom % 100);
      d  = mlen(tobcd(mo), tobcd(y)) - int'($urandom % 2);
      do_load(8'h57, 8'h59, 8'h23, tobcd(1 + int'($urandom % 7)), tobcd(d), tobcd(mo), tobcd(y));
      if (i % 5 == 0) begin stop = 1; cyc(37); stop = 0; end
      cyc(8 * SEC);
    end
    osc_mode = 0;
    cyc(4);
    finish_up();
  end

endmodule